// File: doc/BRIEF.md
# Floating-point access permission checker

This block decides, for one floating-point or vector-SIMD instruction, whether it may run. The inputs are the current privilege level (0 to 3), the security state, and two flags. The first flag says whether the instruction is SIMD-only. The second says whether the floating-point enable bit must be consulted.

Three layers of control fields feed the decision:
- an operating-system access field, made of a 2-bit coprocessor-10 access code and a SIMD-disable bit;
- a non-secure restriction set, which can override both the operating-system layer and the hypervisor layer;
- a hypervisor trap register.

A monitor-level floating-point trap bit is checked last. The checks run in a fixed order, and the first one that fails sets the verdict. A hypervisor trap also carries a 25-bit syndrome.

The decision logic is combinational. A parameter can add one output register stage. The default build registers the outputs, so the verdict appears one clock after the inputs are applied. Exception entry, register storage and 64-bit execution-state behaviour are handled elsewhere.

Top module: `fp_access_gate`

## Requirements
- R1: The verdict is encoded as 2'b00 allow, 2'b01 undefined, 2'b10 hypervisor trap and 2'b11 monitor trap. While reset is held, the registered outputs read allow with an all-zero syndrome.
- R2: The non-secure overrides apply only when a monitor level is present (parameter) and `nonsecure` is 1. In that case, `ns_simd_off`=1 forces both the operating-system SIMD-disable bit and the hypervisor SIMD-trap bit to 1. Likewise, `ns_cp_en`=0 forces the operating-system access code to 00 and the hypervisor coprocessor-10 trap bit to 1. In the secure state the overrides have no effect.
- R3: The operating-system layer is skipped at level 2. At any other level, a SIMD instruction (`is_simd`=1) with the SIMD-disable bit set is undefined.
- R4: The operating-system access code, checked at levels other than 2, has three legal values. Code 00 gives undefined at every level. Code 01 gives undefined at level 0 only. Code 11 imposes no restriction.
- R5: The reserved access code 10 is replaced by the parameter RSV_MAP (default 00, deny) before it is decoded.
- R6: When `chk_fpen`=1 and `fp_en`=0, the verdict is undefined. This check applies at every level. It comes after the operating-system layer and before the hypervisor layer.
- R7: The hypervisor layer applies only when level 2 exists (parameter) and `nonsecure`=1. It fires when (`is_simd` and the SIMD-trap bit) is true, or when the coprocessor-10 trap bit is set. When it fires, the verdict is hypervisor trap.
- R8: The hypervisor-trap syndrome is built as follows. Bits 24:20 carry `cond`. For a SIMD access, bit 5 is 1. For a non-SIMD access, bit 5 is 0 and bits 3:0 are 4'b1010. All other bits are 0. For every other verdict, the syndrome is all zero.
- R9: A hypervisor-layer hit while already at level 2 gives undefined instead of a hypervisor trap.
- R10: If no earlier check failed, `mon_fp_trap`=1 gives a monitor trap.
- R11: Priority runs in this order: operating-system layer, then floating-point enable, then hypervisor layer, then monitor trap.
- R12: With REG_OUT=1, the outputs change only at a clock edge. They show the decision for the inputs present at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| nonsecure | input | 1 | 1 when executing in the non-secure state |
| is_simd | input | 1 | Instruction is SIMD-only |
| chk_fpen | input | 1 | Consult the floating-point enable bit |
| os_simd_off | input | 1 | Operating-system SIMD-disable bit |
| os_cp_acc | input | 2 | Operating-system coprocessor-10 access code |
| ns_simd_off | input | 1 | Non-secure SIMD restriction |
| ns_cp_en | input | 1 | Non-secure coprocessor-10 enable |
| fp_en | input | 1 | Floating-point enable bit |
| hyp_simd_trap | input | 1 | Hypervisor SIMD trap bit |
| hyp_cp_trap | input | 1 | Hypervisor coprocessor-10 trap bit |
| mon_fp_trap | input | 1 | Monitor-level floating-point trap bit |
| cond | input | 5 | Condition field copied into the syndrome |
| verdict | output | 2 | Decision, encoded as in R1 |
| syndrome | output | 25 | Hypervisor-trap syndrome, zero otherwise |

## Verification
The bench targets the places where layered permissions are easy to get wrong.

**Level 2.** Here the operating-system layer must be bypassed, but a hypervisor-layer hit must still end in undefined. A design that lets level 2 take a hypervisor trap, or that applies the operating-system code there, gives the wrong verdict.

**Non-secure overrides.** These are only visible at level 2 through the hypervisor layer, and they must vanish in the secure state. A missing or ungated override shows up as allow where undefined is expected, or the reverse.

**Reserved code, priority and syndrome.** The bench also checks:
- that the reserved code 10 is denied;
- that the first failing check wins when several fail at once (for example, a monitor trap hidden behind a hypervisor trap);
- the exact syndrome bits for SIMD and non-SIMD traps, so that a swapped bit 5 or a missing 1010 nibble is caught.

// File: rtl/fp_access_gate.sv
module fp_access_gate #(
  parameter bit       HYP_PRESENT = 1'b1,
  parameter bit       MON_PRESENT = 1'b1,
  parameter bit [1:0] RSV_MAP     = 2'b00,
  parameter bit       REG_OUT     = 1'b1,
  parameter int       SYN_W       = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       priv_lvl,
  input  logic             nonsecure,
  input  logic             is_simd,
  input  logic             chk_fpen,
  input  logic             os_simd_off,
  input  logic [1:0]       os_cp_acc,
  input  logic             ns_simd_off,
  input  logic             ns_cp_en,
  input  logic             fp_en,
  input  logic             hyp_simd_trap,
  input  logic             hyp_cp_trap,
  input  logic             mon_fp_trap,
  input  logic [4:0]       cond,
  output logic [1:0]       verdict,
  output logic [SYN_W-1:0] syndrome
);
  localparam logic [1:0] V_OK  = 2'b00;
  localparam logic [1:0] V_UND = 2'b01;
  localparam logic [1:0] V_HYP = 2'b10;
  localparam logic [1:0] V_MON = 2'b11;

  logic             ns_lim, at_hyp_lvl;
  logic             simd_off_eff, os_deny, hyp_hit;
  logic [1:0]       acc_eff;
  logic [1:0]       v_nxt;
  logic [SYN_W-1:0] syn_nxt;

  assign ns_lim     = MON_PRESENT && nonsecure;
  assign at_hyp_lvl = (priv_lvl == 2'd2);

  assign simd_off_eff = os_simd_off | (ns_lim & ns_simd_off);

  always_comb begin
    acc_eff = (ns_lim && !ns_cp_en) ? 2'b00 : os_cp_acc;
    if (acc_eff == 2'b10) acc_eff = RSV_MAP;
    case (acc_eff)
      2'b11:   os_deny = 1'b0;
      2'b01:   os_deny = (priv_lvl == 2'd0);
      default: os_deny = 1'b1;
    endcase
  end

  assign hyp_hit = HYP_PRESENT && nonsecure &&
                   ((is_simd && (hyp_simd_trap || (ns_lim && ns_simd_off))) ||
                    hyp_cp_trap || (ns_lim && !ns_cp_en));

  always_comb begin
    v_nxt   = V_OK;
    syn_nxt = '0;
    if (!at_hyp_lvl && ((is_simd && simd_off_eff) || os_deny)) begin
      v_nxt = V_UND;
    end else if (chk_fpen && !fp_en) begin
      v_nxt = V_UND;
    end else if (hyp_hit) begin
      if (at_hyp_lvl) begin
        v_nxt = V_UND;
      end else begin
        v_nxt          = V_HYP;
        syn_nxt[24:20] = cond;
        syn_nxt[5]     = is_simd;
        syn_nxt[3:0]   = is_simd ? 4'b0000 : 4'b1010;
      end
    end else if (mon_fp_trap) begin
      v_nxt = V_MON;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          verdict  <= V_OK;
          syndrome <= '0;
        end else begin
          verdict  <= v_nxt;
          syndrome <= syn_nxt;
        end
      end

      p_reg_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (verdict == $past(v_nxt) && syndrome == $past(syn_nxt)));
    end else begin : g_comb
      assign verdict  = v_nxt;
      assign syndrome = syn_nxt;
    end
  endgenerate

  p_lvl2_no_hyp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    at_hyp_lvl |-> v_nxt != V_HYP);

  p_deny_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_hyp_lvl && os_cp_acc == 2'b00) |-> v_nxt == V_UND);

  p_fpen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fpen && !fp_en) |-> v_nxt == V_UND);

  p_mon_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mon_fp_trap |-> v_nxt != V_OK);

  p_secure_no_hyp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !nonsecure |-> v_nxt != V_HYP);

  p_syn_fmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (v_nxt == V_HYP) |-> (syn_nxt[24:20] == cond && syn_nxt[5] == is_simd &&
                          syn_nxt[3:0] == (is_simd ? 4'h0 : 4'hA)));

  p_syn_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (v_nxt != V_HYP) |-> syn_nxt == '0);
endmodule

// File: tb/fp_access_gate_bench.sv
module fp_access_gate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv_lvl;
  logic        nonsecure, is_simd, chk_fpen, os_simd_off;
  logic [1:0]  os_cp_acc;
  logic        ns_simd_off, ns_cp_en, fp_en, hyp_simd_trap, hyp_cp_trap, mon_fp_trap;
  logic [4:0]  cond;
  logic [1:0]  verdict;
  logic [24:0] syndrome;

  int n_chk = 0;
  int n_err = 0;

  localparam logic [1:0] OK = 2'b00, UND = 2'b01, HYP = 2'b10, MON = 2'b11;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_access_gate u_fp_access_gate (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .nonsecure(nonsecure),
    .is_simd(is_simd), .chk_fpen(chk_fpen), .os_simd_off(os_simd_off),
    .os_cp_acc(os_cp_acc), .ns_simd_off(ns_simd_off), .ns_cp_en(ns_cp_en),
    .fp_en(fp_en), .hyp_simd_trap(hyp_simd_trap), .hyp_cp_trap(hyp_cp_trap),
    .mon_fp_trap(mon_fp_trap), .cond(cond), .verdict(verdict), .syndrome(syndrome)
  );

  task automatic open_all();
    priv_lvl = 2'd1; nonsecure = 1'b1; is_simd = 1'b0; chk_fpen = 1'b1;
    os_simd_off = 1'b0; os_cp_acc = 2'b11; ns_simd_off = 1'b0; ns_cp_en = 1'b1;
    fp_en = 1'b1; hyp_simd_trap = 1'b0; hyp_cp_trap = 1'b0; mon_fp_trap = 1'b0;
    cond = 5'd0;
  endtask

  task automatic expect_now(input logic [1:0] ev, input logic [24:0] es, input string tag);
    n_chk++;
    if (verdict !== ev || syndrome !== es) begin
      n_err++;
      $display("FAIL %s: verdict=%b syndrome=%h expected verdict=%b syndrome=%h",
               tag, verdict, syndrome, ev, es);
    end
  endtask

  task automatic settle_check(input logic [1:0] ev, input logic [24:0] es, input string tag);
    @(posedge clk);
    @(negedge clk);
    expect_now(ev, es, tag);
  endtask

  task automatic t_reset();
    open_all();
    mon_fp_trap = 1'b1;
    @(negedge clk);
    expect_now(OK, 25'd0, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    open_all();
    settle_check(OK, 25'd0, "R1 open allow");
  endtask

  task automatic t_os_code();
    open_all(); priv_lvl = 2'd0; os_cp_acc = 2'b01;
    settle_check(UND, 25'd0, "R4 code01 level0");
    priv_lvl = 2'd1;
    settle_check(OK, 25'd0, "R4 code01 level1");
    os_cp_acc = 2'b00;
    settle_check(UND, 25'd0, "R4 code00 level1");
    priv_lvl = 2'd0; os_cp_acc = 2'b11;
    settle_check(OK, 25'd0, "R4 code11 level0");
    priv_lvl = 2'd3; os_cp_acc = 2'b00; nonsecure = 1'b0;
    settle_check(UND, 25'd0, "R4 code00 level3");
  endtask

  task automatic t_reserved();
    open_all(); os_cp_acc = 2'b10;
    settle_check(UND, 25'd0, "R5 reserved code maps to deny");
    priv_lvl = 2'd0;
    settle_check(UND, 25'd0, "R5 reserved code level0");
  endtask

  task automatic t_simd_off();
    open_all(); is_simd = 1'b1; os_simd_off = 1'b1;
    settle_check(UND, 25'd0, "R3 simd disabled level1");
    is_simd = 1'b0;
    settle_check(OK, 25'd0, "R3 non-simd ignores simd-disable");
    priv_lvl = 2'd2; is_simd = 1'b1; os_cp_acc = 2'b00;
    settle_check(OK, 25'd0, "R3 level2 skips os layer");
  endtask

  task automatic t_fpen();
    open_all(); fp_en = 1'b0;
    settle_check(UND, 25'd0, "R6 fp enable clear");
    chk_fpen = 1'b0;
    settle_check(OK, 25'd0, "R6 enable not consulted");
    chk_fpen = 1'b1; priv_lvl = 2'd2;
    settle_check(UND, 25'd0, "R6 fp enable clear level2");
  endtask

  task automatic t_hyp();
    open_all(); hyp_cp_trap = 1'b1; cond = 5'h1A;
    settle_check(HYP, {5'h1A, 14'd0, 1'b0, 1'b0, 4'hA}, "R8 non-simd syndrome");
    open_all(); is_simd = 1'b1; hyp_simd_trap = 1'b1; cond = 5'h03;
    settle_check(HYP, {5'h03, 14'd0, 1'b1, 5'd0}, "R8 simd syndrome");
    is_simd = 1'b0;
    settle_check(OK, 25'd0, "R7 simd trap ignores non-simd");
    open_all(); hyp_cp_trap = 1'b1; nonsecure = 1'b0;
    settle_check(OK, 25'd0, "R7 secure skips hyp layer");
    priv_lvl = 2'd0; nonsecure = 1'b1; cond = 5'h1F;
    settle_check(HYP, {5'h1F, 14'd0, 1'b0, 1'b0, 4'hA}, "R7 level0 hyp trap");
  endtask

  task automatic t_ns_override();
    open_all(); ns_cp_en = 1'b0;
    settle_check(UND, 25'd0, "R2 ns cp disable forces os code 00");
    nonsecure = 1'b0;
    settle_check(OK, 25'd0, "R2 secure ignores ns cp disable");
    open_all(); priv_lvl = 2'd2; ns_cp_en = 1'b0;
    settle_check(UND, 25'd0, "R2 ns cp disable forces hyp trap at level2");
    open_all(); priv_lvl = 2'd2; is_simd = 1'b1; ns_simd_off = 1'b1;
    settle_check(UND, 25'd0, "R2 ns simd off forces hyp simd trap");
    open_all(); is_simd = 1'b1; ns_simd_off = 1'b1;
    settle_check(UND, 25'd0, "R2 ns simd off forces os simd disable");
    nonsecure = 1'b0;
    settle_check(OK, 25'd0, "R2 secure ignores ns simd off");
  endtask

  task automatic t_lvl2();
    open_all(); priv_lvl = 2'd2; hyp_cp_trap = 1'b1; cond = 5'h0E;
    settle_check(UND, 25'd0, "R9 hyp hit at level2 is undefined");
  endtask

  task automatic t_mon();
    open_all(); mon_fp_trap = 1'b1;
    settle_check(MON, 25'd0, "R10 monitor trap");
    priv_lvl = 2'd3; nonsecure = 1'b0;
    settle_check(MON, 25'd0, "R10 monitor trap level3");
  endtask

  task automatic t_priority();
    open_all(); mon_fp_trap = 1'b1; hyp_cp_trap = 1'b1; cond = 5'h05;
    settle_check(HYP, {5'h05, 14'd0, 1'b0, 1'b0, 4'hA}, "R11 hyp before monitor");
    fp_en = 1'b0;
    settle_check(UND, 25'd0, "R11 fp enable before hyp");
    fp_en = 1'b1; os_cp_acc = 2'b00;
    settle_check(UND, 25'd0, "R11 os layer first");
  endtask

  task automatic t_latency();
    open_all();
    settle_check(OK, 25'd0, "R12 baseline");
    mon_fp_trap = 1'b1;
    #1;
    expect_now(OK, 25'd0, "R12 holds before edge");
    settle_check(MON, 25'd0, "R12 updates after edge");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_os_code();
        t_reserved();
        t_simd_off();
        t_fpen();
        t_hyp();
        t_ns_override();
        t_lvl2();
        t_mon();
        t_priority();
        t_latency();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule